// File: doc/BRIEF.md
# Latched Discharge Fault Recovery Controller

This block holds two latched discharge-current faults, a short-circuit latch (index 0) and an overcurrent latch (index 1), and decides when each may be released. A latch is set by a one-cycle fault-detect pulse that comes from outside the block. While set, it can be cleared in three ways: a load-removal flag, a host clear command, or sustained charge current. The current path can be switched on or off per latch.

The charge-current path is qualified on a signed current sample stream with a valid strobe. Charge current is positive. Each latch has its own threshold and its own recovery time, counted in valid samples. Every release produces a one-cycle pulse with a 2-bit code that names the path that caused it, so the surrounding protection logic can log the event and re-arm its drivers. Current measurement, fault detection and switch driving sit outside this block.

Top module: `ocr_recovery_top`

## Requirements
- R1: A high `fault_set[i]` sets latch i at the next clock edge. The latch then stays set until a recovery path clears it.
- R2: A high `load_removed[i]` while latch i is set clears it at the next edge and emits a recovery pulse with cause code 2'b01.
- R3: A high `host_clear[i]` while latch i is set clears it at the next edge and emits a recovery pulse with cause code 2'b10.
- R4: With current recovery enabled, latch i clears when the current reaches the recovery time (a count of consecutive valid samples, each at or above its threshold), with cause code 2'b11. The clear takes effect at the edge that accepts the last such sample. A time setting of 0 acts as 1. Samples with `cur_valid` low neither count nor reset the run. A valid sample below the threshold restarts the count.
- R5: The current-recovery enables are registered. They take effect one cycle after they are driven and reset to 0. While an enable is 0, charge current never clears that latch.
- R6: The threshold compare treats the sample and the threshold as two's-complement signed values, so a discharge (negative) sample never qualifies against a positive threshold.
- R7: If `fault_set[i]` is high in the same cycle as a clear condition, latch i stays set and no pulse is emitted.
- R8: A recovery pulse lasts exactly one cycle and appears at the edge where the latch falls. The cause code is 2'b00 when no pulse is present. When clear paths coincide, the priority is load removal, then host, then current.
- R9: After reset, both latches are clear, no pulses are active and both cause codes are 2'b00.
- R10: The two latches are independent. Inputs for one latch never change the state or outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_sample | input | CUR_W | Signed current sample, charge positive |
| cur_valid | input | 1 | Sample strobe |
| thr_short | input | CUR_W | Signed recovery threshold, short-circuit latch |
| thr_over | input | CUR_W | Signed recovery threshold, overcurrent latch |
| rtime_short | input | TIME_W | Recovery time in valid samples, short-circuit latch |
| rtime_over | input | TIME_W | Recovery time in valid samples, overcurrent latch |
| cur_rec_en | input | 2 | Current-recovery enable per latch (bit 0 short, bit 1 over) |
| fault_set | input | 2 | Fault-detect pulses per latch |
| load_removed | input | 2 | Load-removal indication per latch |
| host_clear | input | 2 | Host clear command per latch |
| latch_q | output | 2 | Latch states |
| rec_pulse | output | 2 | One-cycle recovery pulses |
| cause_short | output | 2 | Cause code for the short-circuit latch pulse |
| cause_over | output | 2 | Cause code for the overcurrent latch pulse |

## Verification
A wrong sample counter shows at `latch_q` as a release that is one or more valid samples early or late. It is visible at the edge that should have accepted the final qualifying sample. A wrong enable register or a wrong sign in the compare shows as a release that should never happen, with cause 2'b11. A wrong priority between set and clear, or between clear paths, shows in the very next cycle as a missing latch, an unexpected pulse or the wrong cause code. Because the latches are independent, the bench drives both latches in the same cycles to expose any leak from one latch into the other.

// File: rtl/ocr_pkg.sv
package ocr_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_LOAD = 2'b01,
    CAUSE_HOST = 2'b10,
    CAUSE_CURR = 2'b11
  } cause_e;

  // Priority among simultaneous clear paths: load, then host, then current.
  function automatic cause_e pick_cause(input logic load, input logic host, input logic curr);
    if (load)      return CAUSE_LOAD;
    else if (host) return CAUSE_HOST;
    else if (curr) return CAUSE_CURR;
    else           return CAUSE_NONE;
  endfunction
endpackage

// File: rtl/ocr_charge_timer.sv
module ocr_charge_timer #(
  parameter int CUR_W  = 16,
  parameter int TIME_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     armed,
  input  logic                     restart,
  input  logic signed [CUR_W-1:0]  sample,
  input  logic                     valid,
  input  logic signed [CUR_W-1:0]  thresh,
  input  logic        [TIME_W-1:0] rtime,
  output logic                     done,
  output logic        [TIME_W-1:0] cnt_o
);
  localparam logic [TIME_W-1:0] CNT_MAX = {TIME_W{1'b1}};

  function automatic logic at_or_above(input logic signed [CUR_W-1:0] s,
                                       input logic signed [CUR_W-1:0] t);
    return s >= t;
  endfunction

  function automatic logic [TIME_W-1:0] sat_inc(input logic [TIME_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  function automatic logic [TIME_W-1:0] needed(input logic [TIME_W-1:0] r);
    return (r == '0) ? {{(TIME_W-1){1'b0}}, 1'b1} : r;
  endfunction

  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W-1:0] cnt_nxt;
  logic              qual;

  assign qual    = valid && at_or_above(sample, thresh);
  assign cnt_nxt = sat_inc(cnt_q);
  assign done    = armed && qual && (cnt_nxt >= needed(rtime));
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!armed || restart || done) begin
      cnt_q <= '0;
    end else if (valid) begin
      cnt_q <= qual ? cnt_nxt : '0;
    end
  end

  AST_DONE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (valid && armed)); // R4
  AST_BELOW_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !qual) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/ocr_latch_cell.sv
module ocr_latch_cell
  import ocr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fault_set,
  input  logic   load_rm,
  input  logic   host_clr,
  input  logic   cur_done,
  output logic   latched,
  output logic   pulse,
  output cause_e cause,
  output logic   clr_evt
);
  logic clr_req;

  assign clr_req = load_rm || host_clr || cur_done;
  assign clr_evt = latched && clr_req && !fault_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched <= 1'b0;
      pulse   <= 1'b0;
      cause   <= CAUSE_NONE;
    end else begin
      if (fault_set)    latched <= 1'b1;
      else if (clr_evt) latched <= 1'b0;
      pulse <= clr_evt;
      cause <= clr_evt ? pick_cause(load_rm, host_clr, cur_done) : CAUSE_NONE;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set |=> (latched && !pulse)); // R7
  AST_FALL_HAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latched) |-> pulse); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R8
  AST_CAUSE_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse == (cause != CAUSE_NONE)); // R8
  AST_PULSE_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> !latched); // R2
endmodule

// File: rtl/ocr_recovery_top.sv
module ocr_recovery_top
  import ocr_pkg::*;
#(
  parameter int CUR_W  = 16,
  parameter int TIME_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [CUR_W-1:0]  cur_sample,
  input  logic                     cur_valid,
  input  logic signed [CUR_W-1:0]  thr_short,
  input  logic signed [CUR_W-1:0]  thr_over,
  input  logic        [TIME_W-1:0] rtime_short,
  input  logic        [TIME_W-1:0] rtime_over,
  input  logic        [1:0]        cur_rec_en,
  input  logic        [1:0]        fault_set,
  input  logic        [1:0]        load_removed,
  input  logic        [1:0]        host_clear,
  output logic        [1:0]        latch_q,
  output logic        [1:0]        rec_pulse,
  output logic        [1:0]        cause_short,
  output logic        [1:0]        cause_over
);
  localparam int NUM_LATCH = 2;

  logic [NUM_LATCH-1:0]       en_q;
  logic [NUM_LATCH-1:0]       cur_done;
  logic [NUM_LATCH-1:0]       clr_evt;
  logic signed [CUR_W-1:0]    thr_arr   [NUM_LATCH];
  logic        [TIME_W-1:0]   rtime_arr [NUM_LATCH];
  logic        [TIME_W-1:0]   cnt_arr   [NUM_LATCH];
  cause_e                     cause_arr [NUM_LATCH];

  assign thr_arr[0]   = thr_short;
  assign thr_arr[1]   = thr_over;
  assign rtime_arr[0] = rtime_short;
  assign rtime_arr[1] = rtime_over;
  assign cause_short  = cause_arr[0];
  assign cause_over   = cause_arr[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= cur_rec_en;
  end

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_latch
    ocr_charge_timer #(.CUR_W(CUR_W), .TIME_W(TIME_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed   (latch_q[i] && en_q[i]),
      .restart (clr_evt[i] || fault_set[i]),
      .sample  (cur_sample),
      .valid   (cur_valid),
      .thresh  (thr_arr[i]),
      .rtime   (rtime_arr[i]),
      .done    (cur_done[i]),
      .cnt_o   (cnt_arr[i])
    );

    ocr_latch_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .fault_set (fault_set[i]),
      .load_rm   (load_removed[i]),
      .host_clr  (host_clear[i]),
      .cur_done  (cur_done[i]),
      .latched   (latch_q[i]),
      .pulse     (rec_pulse[i]),
      .cause     (cause_arr[i]),
      .clr_evt   (clr_evt[i])
    );

    AST_CURR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_pulse[i] && cause_arr[i] == CAUSE_CURR) |-> $past(en_q[i])); // R5
    AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_q[i] |-> (cnt_arr[i] == '0)); // R4
  end
endmodule

// File: tb/tb_ocr_recovery_top.sv
module tb_ocr_recovery_top;
  localparam int CLK_PERIOD = 10;
  localparam int CUR_W = 16;
  localparam int TIME_W = 8;
  localparam int NROW = 19;

  // [32:31] set, [30:29] load, [28:27] host, [26:25] en, [24] valid,
  // [23:8] sample, [7:6] latch, [5:4] pulse, [3:2] cause_short, [1:0] cause_over
  localparam logic [32:0] VEC [NROW] = '{
    {2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 16'd0,    8'b11_00_00_00},
    {2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 16'd200,  8'b11_00_00_00},
    {2'b00, 2'b00, 2'b01, 2'b00, 1'b0, 16'd0,    8'b10_01_10_00},
    {2'b00, 2'b10, 2'b00, 2'b00, 1'b0, 16'd0,    8'b00_10_00_01},
    {2'b11, 2'b00, 2'b00, 2'b11, 1'b0, 16'd0,    8'b11_00_00_00},
    {2'b00, 2'b00, 2'b00, 2'b11, 1'b1, 16'd60,   8'b11_00_00_00},
    {2'b00, 2'b00, 2'b00, 2'b11, 1'b1, 16'd60,   8'b01_10_00_11},
    {2'b00, 2'b00, 2'b00, 2'b11, 1'b1, 16'd150,  8'b01_00_00_00},
    {2'b00, 2'b00, 2'b00, 2'b11, 1'b0, 16'd150,  8'b01_00_00_00},
    {2'b00, 2'b00, 2'b00, 2'b11, 1'b1, 16'd40,   8'b01_00_00_00},
    {2'b00, 2'b00, 2'b00, 2'b11, 1'b1, 16'd150,  8'b01_00_00_00},
    {2'b00, 2'b00, 2'b00, 2'b11, 1'b1, 16'd150,  8'b01_00_00_00},
    {2'b00, 2'b00, 2'b00, 2'b11, 1'b1, 16'd150,  8'b00_01_11_00},
    {2'b01, 2'b00, 2'b00, 2'b11, 1'b0, 16'd0,    8'b01_00_00_00},
    {2'b01, 2'b00, 2'b01, 2'b11, 1'b0, 16'd0,    8'b01_00_00_00},
    {2'b00, 2'b00, 2'b00, 2'b11, 1'b1, 16'hFF38, 8'b01_00_00_00},
    {2'b00, 2'b00, 2'b00, 2'b11, 1'b1, 16'hFF38, 8'b01_00_00_00},
    {2'b00, 2'b00, 2'b00, 2'b11, 1'b1, 16'hFF38, 8'b01_00_00_00},
    {2'b00, 2'b01, 2'b01, 2'b11, 1'b0, 16'd0,    8'b00_01_01_00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [CUR_W-1:0] cur_sample = '0;
  logic cur_valid = 1'b0;
  logic signed [CUR_W-1:0] thr_short = 16'sd100;
  logic signed [CUR_W-1:0] thr_over = 16'sd50;
  logic [TIME_W-1:0] rtime_short = 8'd3;
  logic [TIME_W-1:0] rtime_over = 8'd2;
  logic [1:0] cur_rec_en = '0, fault_set = '0, load_removed = '0, host_clear = '0;
  logic [1:0] latch_q, rec_pulse, cause_short, cause_over;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocr_recovery_top #(.CUR_W(CUR_W), .TIME_W(TIME_W)) dut (
    .clk(clk), .rst_n(rst_n), .cur_sample(cur_sample), .cur_valid(cur_valid),
    .thr_short(thr_short), .thr_over(thr_over), .rtime_short(rtime_short),
    .rtime_over(rtime_over), .cur_rec_en(cur_rec_en), .fault_set(fault_set),
    .load_removed(load_removed), .host_clear(host_clear), .latch_q(latch_q),
    .rec_pulse(rec_pulse), .cause_short(cause_short), .cause_over(cause_over)
  );

  function automatic string row_tag(input int i);
    case (i)
      0, 4, 13:               return "R1";
      1:                      return "R5";
      2:                      return "R3";
      3:                      return "R2 R10";
      6:                      return "R4 R10";
      14:                     return "R7";
      15, 16, 17:             return "R6";
      18:                     return "R8";
      default:                return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", {latch_q, rec_pulse, cause_short, cause_over}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", {latch_q, rec_pulse, cause_short, cause_over}, 8'h00);

    for (int i = 0; i < NROW; i++) begin
      fault_set    = VEC[i][32:31];
      load_removed = VEC[i][30:29];
      host_clear   = VEC[i][28:27];
      cur_rec_en   = VEC[i][26:25];
      cur_valid    = VEC[i][24];
      cur_sample   = VEC[i][23:8];
      @(negedge clk);
      check(row_tag(i), {latch_q, rec_pulse, cause_short, cause_over}, VEC[i][7:0]);
    end

    // R4: time setting 0 acts as one sample
    fault_set = '0; load_removed = '0; host_clear = '0; cur_valid = 1'b0;
    rtime_over = 8'd0;
    fault_set = 2'b10;
    @(negedge clk);
    check("R4 rtime0 set", {latch_q, rec_pulse, cause_short, cause_over}, 8'b10_00_00_00);
    fault_set = 2'b00; cur_valid = 1'b1; cur_sample = 16'sd60;
    @(negedge clk);
    check("R4 rtime0 clear", {latch_q, rec_pulse, cause_short, cause_over}, 8'b00_10_00_11);

    // R5: disabling the enable stops current recovery on the next cycle
    cur_valid = 1'b0; fault_set = 2'b01; cur_rec_en = 2'b00;
    @(negedge clk);
    fault_set = 2'b00; cur_valid = 1'b1; cur_sample = 16'sd500;
    repeat (4) @(negedge clk);
    check("R5 disabled", {latch_q, rec_pulse, cause_short, cause_over}, 8'b01_00_00_00);

    // R9: reset mid-run clears everything
    cur_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check("R9 midrun", {latch_q, rec_pulse, cause_short, cause_over}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule